// File: doc/BRIEF.md
# Bufferless Fat-Tree Switching Element

This block is one switch of a fat-tree on-chip network in which each input has its own downward path. Its row and column in the tree are fixed when it is built. Three constants follow from them: a base address, a split point and an end address. Together they define the half-open range of client addresses that sit below this switch. The split point divides that range into a left half and a right half. Packets are wormhole-routed and carry flits. The first flit of a packet holds the destination address. A tail flag marks the last flit.

The switch stores no flits and has no arbiter. A flit that arrives on an input leaves on an output in the same cycle. The header flit selects the output, and the path it selects stays locked until the tail has passed. Each input, whether it enters from below or from above, owns a private left output and a private right output, so two inputs never compete on the way down. Only inputs from below may climb. There are as many upward outputs as there are inputs from below, and a climbing packet takes the lowest-numbered upward output that is free when its header arrives. Upward routing therefore never contends either.

Top module: `fatr_router`

## Requirements
- R1: With ROW r and COL c, the base is c with its low r bits cleared, the split is base + 2^(r-1) and the end is base + 2^r. The defaults (r=2, c=5) give 4, 6 and 8. The destination is the low ADDR_W bits of the header flit's data field.
- R2: A header on input i from below whose destination lies in [base, split) leaves on left output i. One whose destination lies in [split, end) leaves on right output i.
- R3: A header from below whose destination is under base, or at or above end, leaves on an upward output and on no left or right output.
- R4: An input from above never drives an upward output. Its header goes to its own left output (index N_DN + k) when the destination is under split, and to its own right output otherwise.
- R5: A climbing header takes the lowest-numbered upward output that is not held by a packet in flight. When several headers climb in the same cycle, the lower-numbered input gets the lower-numbered free output.
- R6: Every flit after a header that lacks a tail follows the header's output, whatever its data bits hold. Cycles in which the input carries no flit do not break the lock.
- R7: A path is released in the cycle after its tail flit. The next flit on that input is decoded as a header. An upward output freed by a tail cannot be taken by another header in the tail's own cycle.
- R8: A flit that carries both header and tail is routed alone and leaves no lock behind.
- R9: An output's valid is high only in a cycle in which its source input presents a valid flit, and it carries that flit's data and tail unchanged in the same cycle. Every valid input flit appears on exactly one output.
- R10: Reset clears all locks, so the first flit on any input after reset is decoded as a header, and with idle inputs every output valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dn_in_vld | input | N_DN | Flit valid, inputs from below |
| dn_in_tail | input | N_DN | Last-flit flag, inputs from below |
| dn_in_data | input | N_DN x DATA_W | Flit data, inputs from below |
| up_in_vld | input | N_UI | Flit valid, inputs from above |
| up_in_tail | input | N_UI | Last-flit flag, inputs from above |
| up_in_data | input | N_UI x DATA_W | Flit data, inputs from above |
| up_out_vld | output | N_DN | Flit valid, upward outputs |
| up_out_tail | output | N_DN | Last-flit flag, upward outputs |
| up_out_data | output | N_DN x DATA_W | Flit data, upward outputs |
| lft_out_vld | output | N_DN+N_UI | Valid of each input's private left output |
| lft_out_tail | output | N_DN+N_UI | Last-flit flag, left outputs |
| lft_out_data | output | (N_DN+N_UI) x DATA_W | Flit data, left outputs |
| rgt_out_vld | output | N_DN+N_UI | Valid of each input's private right output |
| rgt_out_tail | output | N_DN+N_UI | Last-flit flag, right outputs |
| rgt_out_data | output | (N_DN+N_UI) x DATA_W | Flit data, right outputs |

## Verification
The hardest case to reach is the handover of an upward output. One climbing packet sends its tail in the same cycle that another input's header asks to climb. The new header must skip the output that is being released and take the next one. In the following cycle, a fresh header must be able to reclaim the released output. The stimulus reaches this case by locking both upward outputs with multi-flit packets. It then ends them in staggered cycles and places new headers in the exact cycle of each tail and in the cycle after it. It also sends body flits whose data bits look like addresses of a different class, which shows that the lock holds regardless of the data.

// File: rtl/fatr_pkg.sv
package fatr_pkg;

   typedef enum logic [1:0] {
      DIR_UP    = 2'd0,
      DIR_LEFT  = 2'd1,
      DIR_RIGHT = 2'd2
   } dir_e;

   // base of the reachable client range: column with its low ROW bits cleared
   function automatic int range_base(input int row, input int col);
      return (col >> row) << row;
   endfunction

endpackage

// File: rtl/fatr_route_fn.sv
module fatr_route_fn
   import fatr_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int LO     = 4,
   parameter int MID    = 6,
   parameter int HI     = 8,
   parameter bit UPSIDE = 1'b0
) (
   input  logic [ADDR_W-1:0] addr,
   output dir_e              dir
);

   localparam logic [ADDR_W:0] LO_V  = (ADDR_W+1)'(LO);
   localparam logic [ADDR_W:0] MID_V = (ADDR_W+1)'(MID);
   localparam logic [ADDR_W:0] HI_V  = (ADDR_W+1)'(HI);

   logic [ADDR_W:0] a_ext;
   assign a_ext = {1'b0, addr};

   generate
      if (UPSIDE) begin : g_from_above
         // traffic from above is already inside the range: split only
         always_comb begin
            if (a_ext < MID_V) dir = DIR_LEFT;
            else               dir = DIR_RIGHT;
         end
      end else begin : g_from_below
         logic ge_lo, lt_mid, lt_hi;
         assign ge_lo  = (a_ext >= LO_V);
         assign lt_mid = (a_ext <  MID_V);
         assign lt_hi  = (a_ext <  HI_V);
         always_comb begin
            if (!ge_lo || !lt_hi) dir = DIR_UP;
            else if (lt_mid)      dir = DIR_LEFT;
            else                  dir = DIR_RIGHT;
         end
      end
   endgenerate

endmodule

// File: rtl/fatr_in_lock.sv
module fatr_in_lock
   import fatr_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic in_vld,
   input  logic in_tail,
   input  dir_e new_dir,
   output dir_e cur_dir,
   output logic locked,
   output logic hdr
);

   logic lk_act;
   dir_e lk_dir;

   assign locked  = lk_act;
   assign hdr     = in_vld & ~lk_act;
   assign cur_dir = lk_act ? lk_dir : new_dir;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lk_act <= 1'b0;
         lk_dir <= DIR_UP;
      end else if (in_vld) begin
         if (lk_act) begin
            if (in_tail) lk_act <= 1'b0;
         end else if (!in_tail) begin
            lk_act <= 1'b1;
            lk_dir <= new_dir;
         end
      end
   end

endmodule

// File: rtl/fatr_up_alloc.sv
module fatr_up_alloc #(
   parameter int N   = 2,
   parameter int UPW = 1
) (
   input  logic [N-1:0]          req,
   input  logic [N-1:0]          busy,
   output logic [N-1:0][UPW-1:0] pick
);

   always_comb begin
      logic [N-1:0] avail;
      logic         found;
      avail = ~busy;
      for (int i = 0; i < N; i++) begin
         pick[i] = '0;
         found   = 1'b0;
         if (req[i]) begin
            for (int j = 0; j < N; j++) begin
               if (!found && avail[j]) begin
                  found    = 1'b1;
                  pick[i]  = UPW'(j);
                  avail[j] = 1'b0;
               end
            end
         end
      end
   end

endmodule

// File: rtl/fatr_router.sv
module fatr_router
   import fatr_pkg::*;
#(
   parameter int N_DN   = 2,
   parameter int N_UI   = 2,
   parameter int ROW    = 2,
   parameter int COL    = 5,
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic [N_DN-1:0]                       dn_in_vld,
   input  logic [N_DN-1:0]                       dn_in_tail,
   input  logic [N_DN-1:0][DATA_W-1:0]           dn_in_data,
   input  logic [N_UI-1:0]                       up_in_vld,
   input  logic [N_UI-1:0]                       up_in_tail,
   input  logic [N_UI-1:0][DATA_W-1:0]           up_in_data,
   output logic [N_DN-1:0]                       up_out_vld,
   output logic [N_DN-1:0]                       up_out_tail,
   output logic [N_DN-1:0][DATA_W-1:0]           up_out_data,
   output logic [N_DN+N_UI-1:0]                  lft_out_vld,
   output logic [N_DN+N_UI-1:0]                  lft_out_tail,
   output logic [N_DN+N_UI-1:0][DATA_W-1:0]      lft_out_data,
   output logic [N_DN+N_UI-1:0]                  rgt_out_vld,
   output logic [N_DN+N_UI-1:0]                  rgt_out_tail,
   output logic [N_DN+N_UI-1:0][DATA_W-1:0]      rgt_out_data
);

   localparam int N_IN = N_DN + N_UI;
   localparam int UPW  = (N_DN > 1) ? $clog2(N_DN) : 1;
   localparam int LO   = range_base(ROW, COL);
   localparam int MID  = LO + (1 << (ROW - 1));
   localparam int HI   = LO + (1 << ROW);

   generate
      if (ROW < 1 || ROW > ADDR_W)
         $error("fatr_router: ROW must lie in 1..ADDR_W");
      if (COL < 0 || COL >= (1 << ADDR_W))
         $error("fatr_router: COL outside the address space");
      if (N_DN < 1 || N_UI < 1)
         $error("fatr_router: each side needs at least one input");
      if (DATA_W < ADDR_W)
         $error("fatr_router: DATA_W must hold the address");
   endgenerate

   logic [N_IN-1:0]             all_vld;
   logic [N_IN-1:0]             all_tail;
   logic [N_IN-1:0][DATA_W-1:0] all_data;
   dir_e                        rt_dir  [N_IN];
   dir_e                        cur_dir [N_IN];
   logic [N_IN-1:0]             locked;
   logic [N_IN-1:0]             hdr;

   assign all_vld  = {up_in_vld,  dn_in_vld};
   assign all_tail = {up_in_tail, dn_in_tail};
   assign all_data = {up_in_data, dn_in_data};

   // routing decode and path lock for every input
   generate
      for (genvar i = 0; i < N_IN; i++) begin : g_in
         fatr_route_fn #(
            .ADDR_W (ADDR_W),
            .LO     (LO),
            .MID    (MID),
            .HI     (HI),
            .UPSIDE (i >= N_DN)
         ) u_rt (
            .addr (all_data[i][ADDR_W-1:0]),
            .dir  (rt_dir[i])
         );

         fatr_in_lock u_lk (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_vld  (all_vld[i]),
            .in_tail (all_tail[i]),
            .new_dir (rt_dir[i]),
            .cur_dir (cur_dir[i]),
            .locked  (locked[i]),
            .hdr     (hdr[i])
         );

         // private downward pair: flit data passes straight through
         assign lft_out_vld[i]  = all_vld[i] & (cur_dir[i] == DIR_LEFT);
         assign rgt_out_vld[i]  = all_vld[i] & (cur_dir[i] == DIR_RIGHT);
         assign lft_out_tail[i] = lft_out_vld[i] & all_tail[i];
         assign rgt_out_tail[i] = rgt_out_vld[i] & all_tail[i];
         assign lft_out_data[i] = all_data[i];
         assign rgt_out_data[i] = all_data[i];
      end
   endgenerate

   // upward link choice for inputs from below
   logic [N_DN-1:0]          up_req;
   logic [N_DN-1:0]          up_busy;
   logic [N_DN-1:0][UPW-1:0] up_pick;
   logic [N_DN-1:0][UPW-1:0] up_held;
   logic [N_DN-1:0][UPW-1:0] up_sel;

   always_comb begin
      for (int i = 0; i < N_DN; i++)
         up_req[i] = hdr[i] & (rt_dir[i] == DIR_UP);
   end

   always_comb begin
      up_busy = '0;
      for (int i = 0; i < N_DN; i++)
         if (locked[i] && cur_dir[i] == DIR_UP)
            up_busy[up_held[i]] = 1'b1;
   end

   fatr_up_alloc #(
      .N   (N_DN),
      .UPW (UPW)
   ) u_alloc (
      .req  (up_req),
      .busy (up_busy),
      .pick (up_pick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         up_held <= '0;
      end else begin
         for (int i = 0; i < N_DN; i++)
            if (up_req[i]) up_held[i] <= up_pick[i];
      end
   end

   always_comb begin
      for (int i = 0; i < N_DN; i++)
         up_sel[i] = locked[i] ? up_held[i] : up_pick[i];
   end

   // upward output mux: at most one source per link by construction of the allocator
   always_comb begin
      for (int j = 0; j < N_DN; j++) begin
         up_out_vld[j]  = 1'b0;
         up_out_tail[j] = 1'b0;
         up_out_data[j] = '0;
         for (int i = 0; i < N_DN; i++) begin
            if (dn_in_vld[i] && cur_dir[i] == DIR_UP && up_sel[i] == UPW'(j)) begin
               up_out_vld[j]  = 1'b1;
               up_out_tail[j] = up_out_tail[j] | dn_in_tail[i];
               up_out_data[j] = up_out_data[j] | dn_in_data[i];
            end
         end
      end
   end

endmodule

// File: rtl/fatr_router_chk.sv
module fatr_router_chk
   import fatr_pkg::*;
#(
   parameter int N_DN   = 2,
   parameter int N_UI   = 2,
   parameter int ROW    = 2,
   parameter int COL    = 5,
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic [N_DN-1:0]                  dn_in_vld,
   input logic [N_DN-1:0]                  dn_in_tail,
   input logic [N_DN-1:0][DATA_W-1:0]      dn_in_data,
   input logic [N_UI-1:0]                  up_in_vld,
   input logic [N_UI-1:0]                  up_in_tail,
   input logic [N_UI-1:0][DATA_W-1:0]      up_in_data,
   input logic [N_DN-1:0]                  up_out_vld,
   input logic [N_DN+N_UI-1:0]             lft_out_vld,
   input logic [N_DN+N_UI-1:0]             rgt_out_vld
);

   localparam int N_IN = N_DN + N_UI;
   localparam int LO   = range_base(ROW, COL);
   localparam int MID  = LO + (1 << (ROW - 1));
   localparam int HI   = LO + (1 << ROW);
   localparam logic [ADDR_W:0] LO_V  = (ADDR_W+1)'(LO);
   localparam logic [ADDR_W:0] MID_V = (ADDR_W+1)'(MID);
   localparam logic [ADDR_W:0] HI_V  = (ADDR_W+1)'(HI);

   logic [N_IN-1:0] all_vld, all_tail, in_pkt;
   assign all_vld  = {up_in_vld,  dn_in_vld};
   assign all_tail = {up_in_tail, dn_in_tail};

   // independent packet tracker: high while inside a multi-flit packet
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) in_pkt <= '0;
      else
         for (int i = 0; i < N_IN; i++)
            if (all_vld[i]) in_pkt[i] <= ~all_tail[i];
   end

   AST_FLIT_CONSERVE: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(up_out_vld) + $countones(lft_out_vld) + $countones(rgt_out_vld))
         == $countones(all_vld)); // R9

   AST_UP_ONLY_FROM_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(up_out_vld) <= $countones(dn_in_vld)); // R4

   generate
      for (genvar i = 0; i < N_IN; i++) begin : g_all
         AST_OUT_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
            (lft_out_vld[i] || rgt_out_vld[i]) |-> all_vld[i]); // R9

         AST_LOCK_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
            (all_vld[i] && lft_out_vld[i] && !all_tail[i])
               |=> (!all_vld[i] || lft_out_vld[i])); // R6

         AST_LOCK_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
            (all_vld[i] && rgt_out_vld[i] && !all_tail[i])
               |=> (!all_vld[i] || rgt_out_vld[i])); // R6
      end

      for (genvar i = 0; i < N_DN; i++) begin : g_dn
         logic [ADDR_W:0] a;
         logic            h;
         assign a = {1'b0, dn_in_data[i][ADDR_W-1:0]};
         assign h = dn_in_vld[i] & ~in_pkt[i];

         AST_DN_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
            (h && a >= LO_V && a < MID_V) |-> lft_out_vld[i]); // R2

         AST_DN_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
            (h && a >= MID_V && a < HI_V) |-> rgt_out_vld[i]); // R2

         AST_DN_CLIMB: assert property (@(posedge clk) disable iff (!rst_n)
            (h && (a < LO_V || a >= HI_V)) |-> (!lft_out_vld[i] && !rgt_out_vld[i])); // R3
      end

      for (genvar k = 0; k < N_UI; k++) begin : g_ui
         logic [ADDR_W:0] a;
         assign a = {1'b0, up_in_data[k][ADDR_W-1:0]};

         AST_UI_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
            (up_in_vld[k] && !in_pkt[N_DN+k])
               |-> ((a < MID_V) ? lft_out_vld[N_DN+k] : rgt_out_vld[N_DN+k])); // R4
      end
   endgenerate

endmodule

bind fatr_router fatr_router_chk #(
   .N_DN   (N_DN),
   .N_UI   (N_UI),
   .ROW    (ROW),
   .COL    (COL),
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .dn_in_vld   (dn_in_vld),
   .dn_in_tail  (dn_in_tail),
   .dn_in_data  (dn_in_data),
   .up_in_vld   (up_in_vld),
   .up_in_tail  (up_in_tail),
   .up_in_data  (up_in_data),
   .up_out_vld  (up_out_vld),
   .lft_out_vld (lft_out_vld),
   .rgt_out_vld (rgt_out_vld)
);

// File: tb/fatr_router_bench.sv
module fatr_router_bench;

   localparam int N_DN = 2, N_UI = 2, ROW = 2, COL = 5, ADDR_W = 4, DATA_W = 8;
   localparam int N_IN = N_DN + N_UI;
   localparam int C_UP = 0, C_L = 1, C_R = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [N_DN-1:0]             dn_vld, dn_tail;
   logic [N_DN-1:0][DATA_W-1:0] dn_data;
   logic [N_UI-1:0]             ui_vld, ui_tail;
   logic [N_UI-1:0][DATA_W-1:0] ui_data;
   logic [N_DN-1:0]             uo_vld, uo_tail;
   logic [N_DN-1:0][DATA_W-1:0] uo_data;
   logic [N_IN-1:0]             lo_vld, lo_tail, ro_vld, ro_tail;
   logic [N_IN-1:0][DATA_W-1:0] lo_data, ro_data;

   fatr_router #(
      .N_DN(N_DN), .N_UI(N_UI), .ROW(ROW), .COL(COL), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_fatr_router (
      .clk(clk), .rst_n(rst_n),
      .dn_in_vld(dn_vld), .dn_in_tail(dn_tail), .dn_in_data(dn_data),
      .up_in_vld(ui_vld), .up_in_tail(ui_tail), .up_in_data(ui_data),
      .up_out_vld(uo_vld), .up_out_tail(uo_tail), .up_out_data(uo_data),
      .lft_out_vld(lo_vld), .lft_out_tail(lo_tail), .lft_out_data(lo_data),
      .rgt_out_vld(ro_vld), .rgt_out_tail(ro_tail), .rgt_out_data(ro_data)
   );

   int checks = 0;
   int errors = 0;

   // address classes from R1, computed here from the row and column
   localparam int B_LO  = (COL / (2 ** ROW)) * (2 ** ROW);
   localparam int B_MID = B_LO + 2 ** (ROW - 1);
   localparam int B_HI  = B_LO + 2 ** ROW;

   function automatic int cls(input int src, input int a);
      if (src < N_DN) begin
         if (a < B_LO || a >= B_HI) return C_UP;
         return (a < B_MID) ? C_L : C_R;
      end
      return (a < B_MID) ? C_L : C_R;
   endfunction

   // single-flit vectors: source input (0..1 from below, 2..3 from above) and address
   localparam int NV = 14;
   localparam int VSRC [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 2, 2, 3, 3};
   localparam int VADR [NV] = '{0, 3, 4, 5, 6, 7, 8, 15, 4, 7, 2, 6, 5, 13};

   task automatic idle();
      dn_vld = '0; dn_tail = '0; dn_data = '0;
      ui_vld = '0; ui_tail = '0; ui_data = '0;
   endtask

   task automatic drive(input int src, input logic tl, input logic [DATA_W-1:0] d);
      if (src < N_DN) begin
         dn_vld[src] = 1'b1; dn_tail[src] = tl; dn_data[src] = d;
      end else begin
         ui_vld[src-N_DN] = 1'b1; ui_tail[src-N_DN] = tl; ui_data[src-N_DN] = d;
      end
   endtask

   task automatic chk_vld(input string tag, input logic [N_DN-1:0] eu,
                          input logic [N_IN-1:0] el, input logic [N_IN-1:0] er);
      checks++;
      if (uo_vld !== eu || lo_vld !== el || ro_vld !== er) begin
         errors++;
         $display("FAIL %s: up/left/right valid got %b/%b/%b expected %b/%b/%b",
                  tag, uo_vld, lo_vld, ro_vld, eu, el, er);
      end
   endtask

   task automatic chk_val(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      idle();
   endtask

   bit done = 1'b0;

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not complete");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      idle();
      repeat (3) @(negedge clk);
      #1 chk_vld("R10 idle outputs in reset", '0, '0, '0);
      rst_n = 1'b1;

      // table walk: single-flit packets (R1 R2 R3 R4 R8 R9)
      for (int v = 0; v < NV; v++) begin
         logic [DATA_W-1:0] d;
         logic [N_DN-1:0] eu;
         logic [N_IN-1:0] el, er;
         int c;
         step();
         d = DATA_W'(VADR[v] + 16 * (v % 16));
         drive(VSRC[v], 1'b1, d);
         c  = cls(VSRC[v], VADR[v]);
         eu = (c == C_UP) ? N_DN'(1) : '0;
         el = (c == C_L) ? N_IN'(1) << VSRC[v] : '0;
         er = (c == C_R) ? N_IN'(1) << VSRC[v] : '0;
         #1;
         chk_vld($sformatf("R2 R3 R4 vector %0d", v), eu, el, er);
         if (c == C_UP) begin
            chk_val("R9 up data", int'(uo_data[0]), int'(d));
            chk_val("R9 up tail", int'(uo_tail[0]), 1);
         end else if (c == C_L) chk_val("R9 left data", int'(lo_data[VSRC[v]]), int'(d));
         else                   chk_val("R9 right data", int'(ro_data[VSRC[v]]), int'(d));
      end

      // R8: the single flits above left no lock; a header to the right goes right
      step(); drive(0, 1'b1, 8'h06); #1 chk_vld("R8 no lock left behind", '0, '0, 4'b0001 << 0);

      // R6 R7: lock on left with misleading body data and a gap
      step(); drive(0, 1'b0, 8'h04); #1 chk_vld("R6 header left", '0, 4'b0001, '0);
      step(); drive(0, 1'b0, 8'hF7); #1 chk_vld("R6 body follows lock", '0, 4'b0001, '0);
      chk_val("R6 body data", int'(lo_data[0]), 'hF7);
      step(); #1 chk_vld("R9 gap drives nothing", '0, '0, '0);
      step(); drive(0, 1'b1, 8'h0A); #1 chk_vld("R6 tail stays left", '0, 4'b0001, '0);
      chk_val("R9 left tail flag", int'(lo_tail[0]), 1);
      step(); drive(0, 1'b1, 8'h06); #1 chk_vld("R7 released after tail", '0, '0, 4'b0001);

      // R5 R7: upward link allocation and handover
      step(); drive(0, 1'b0, 8'h01); drive(1, 1'b0, 8'h09);
      #1 chk_vld("R5 two climbers", 2'b11, '0, '0);
      chk_val("R5 input0 on link0", int'(uo_data[0]), 'h01);
      chk_val("R5 input1 on link1", int'(uo_data[1]), 'h09);
      step(); drive(0, 1'b0, 8'h55); drive(1, 1'b0, 8'h66);
      #1 chk_val("R6 body link0", int'(uo_data[0]), 'h55);
      chk_val("R6 body link1", int'(uo_data[1]), 'h66);
      step(); drive(0, 1'b1, 8'h77); #1 chk_vld("R6 tail link0", 2'b01, '0, '0);
      step(); drive(0, 1'b0, 8'h02); drive(1, 1'b1, 8'h88);
      #1 chk_val("R7 freed link0 reused", int'(uo_data[0]), 'h02);
      chk_val("R6 tail on link1", int'(uo_data[1]), 'h88);
      step(); drive(0, 1'b0, 8'h33); drive(1, 1'b0, 8'h0C);
      #1 chk_val("R5 skip busy link0", int'(uo_data[1]), 'h0C);
      chk_val("R6 body link0 held", int'(uo_data[0]), 'h33);
      step(); drive(0, 1'b1, 8'h11); drive(1, 1'b1, 8'h22);
      #1 chk_vld("R6 both tails", 2'b11, '0, '0);
      step(); drive(1, 1'b1, 8'h0E);
      #1 chk_vld("R5 lone climber takes link0", 2'b01, '0, '0);
      chk_val("R5 link0 data", int'(uo_data[0]), 'h0E);
      step(); drive(0, 1'b0, 8'h03); #1 chk_vld("R5 lock link0", 2'b01, '0, '0);
      step(); drive(0, 1'b1, 8'h44); drive(1, 1'b1, 8'h0F);
      #1 chk_val("R7 tail keeps link0", int'(uo_data[0]), 'h44);
      chk_val("R7 no reuse in tail cycle", int'(uo_data[1]), 'h0F);

      // R4 R2 R3: all inputs at once, multi-flit
      step(); drive(0, 1'b0, 8'h05); drive(1, 1'b0, 8'h08);
      drive(2, 1'b0, 8'h03); drive(3, 1'b0, 8'h0C);
      #1 chk_vld("R4 concurrent headers", 2'b01, 4'b0101, 4'b1000);
      step(); drive(0, 1'b0, 8'hF6); drive(1, 1'b0, 8'hF5);
      drive(2, 1'b0, 8'hF7); drive(3, 1'b0, 8'hF1);
      #1 chk_vld("R6 concurrent bodies", 2'b01, 4'b0101, 4'b1000);
      chk_val("R9 upside right data", int'(ro_data[3]), 'hF1);
      step(); drive(0, 1'b1, 8'h00); drive(1, 1'b1, 8'h00);
      drive(2, 1'b1, 8'h00); drive(3, 1'b1, 8'h00);
      #1 chk_vld("R6 concurrent tails", 2'b01, 4'b0101, 4'b1000);
      step(); #1 chk_vld("R9 all idle", '0, '0, '0);

      // R10: reset in mid-packet clears the lock
      step(); drive(0, 1'b0, 8'h04); #1 chk_vld("R10 pre-reset header", '0, 4'b0001, '0);
      step(); rst_n = 1'b0;
      step(); rst_n = 1'b1;
      step(); drive(0, 1'b1, 8'h06); #1 chk_vld("R10 lock cleared", '0, '0, 4'b0001);

      step();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule